// File: doc/BRIEF.md
# Two-Step Flash Conversion Decoder

This block is the digital half of a two-step flash converter. The analog side has a rough estimator and a single bank of sixteen comparators. The bank is used twice. In the coarse flash it is routed to a window of sixteen coarse-ladder taps, and the block picks that window from the estimator result. In the fine flash it is routed to the fine-ladder taps, after the analog side has subtracted a coarse tap from the held input. The block sequences these steps and decodes every thermometer vector by counting ones. It then builds a 10-bit code and presents that code with a one-cycle valid pulse.

The coarse-ladder tap index is driven on `win_sel`. During the coarse phase it is the base of the comparator window. During the fine phase it is the coarse code, which selects the tap to subtract. The window reaches one sixteenth of full scale past each edge of the estimator region. An estimate that is off by up to 64 codes therefore still produces the exact result. After every phase change the block waits a programmable number of settle cycles before it samples the comparators.

Top module: `flash2_decoder`

## Requirements
- R1: While reset is high and after it is released, phase is 0, valid is 0, result is 0, win_sel is 0 and bubble is 0.
- R2: A start seen high at a clock edge while phase is 0 makes phase read 1 (estimate), 2 (coarse) and 3 (fine) for SETTLE+1 cycles each, then 4 (latch) for one cycle, then 0. Valid is high in the cycle after the latch cycle, 3*(SETTLE+1)+1 edges after the start edge. With the default SETTLE=1 that is 7 edges.
- R3: Throughout the coarse phase, win_sel equals WIN_STEP (default 8) times the number of ones in est_therm, limited to 63. Comparator i of the bank is expected to compare against coarse tap win_sel+i+1, with each coarse tap worth 16 codes.
- R4: The coarse code equals the coarse-phase win_sel plus the number of ones in bank_therm sampled in the coarse phase, limited to 63. It is shown on win_sel throughout the fine phase and held until the next conversion.
- R5: result equals 16 times the coarse code plus the number of ones in bank_therm sampled in the fine phase, limited to 1023.
- R6: With ideal comparators, an estimator whose thresholds are displaced by up to 64 codes still yields a result equal to the input code.
- R7: bubble is 1 together with the result when any of the three sampled vectors is not of the form 2^n-1 (ones packed from bit 0). The count of ones in that vector is still used.
- R8: A start while phase is not 0 is ignored. Exactly one valid pulse follows a start, and its result comes from the first start's samples.
- R9: valid is high for exactly one cycle. result and bubble hold their values until the next valid pulse.
- R10: Only the comparator values in the last cycle of each of phases 1 to 3 are used. Values present during settle cycles have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a conversion (taken only when idle) |
| est_therm | input | 6 | Estimator comparator outputs, thermometer |
| bank_therm | input | 16 | Shared comparator bank outputs, thermometer |
| phase | output | 3 | 0 idle, 1 estimate, 2 coarse, 3 fine, 4 latch |
| win_sel | output | 6 | Coarse tap index: window base, then coarse code |
| result | output | 10 | Converted code |
| valid | output | 1 | One-cycle pulse when result is updated |
| bubble | output | 1 | Non-monotonic vector seen in the last conversion |

## Verification
The assertions assume that the inputs change only away from the clock edge, and that start comes after reset has been released. The bench drives start at falling edges. The window-hold assertion assumes that whatever routes the bank reads `win_sel` unchanged for a whole phase. The bench's comparator model is combinational in `win_sel` and `phase`. In the settle-cycle test it returns the inverted vectors only in the first cycle of a phase, which it finds by comparing the phase with its value one edge earlier. The coarse-to-fine join check assumes that the fine count never exceeds 16. The bank is 16 bits wide, so any stimulus meets that.

// File: rtl/flash2_pkg.sv
`timescale 1ns/1ps
package flash2_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_EST   = 3'd1,
    PH_CRS   = 3'd2,
    PH_FIN   = 3'd3,
    PH_LATCH = 3'd4
  } phase_t;
endpackage

// File: rtl/flash2_therm_count.sv
`timescale 1ns/1ps
// Counts ones in a thermometer vector and flags a non-packed pattern.
module flash2_therm_count #(
  parameter int W  = 16,
  parameter int OW = $clog2(W + 1)
) (
  input  logic [W-1:0]  therm,
  output logic [OW-1:0] ones,
  output logic          bubble
);
  logic [W-1:0] plus_one;

  always_comb begin
    ones = '0;
    for (int i = 0; i < W; i++) begin
      ones = ones + OW'(therm[i]);
    end
  end

  // A packed pattern 2^n-1 shares no set bit with itself plus one.
  assign plus_one = therm + W'(1);
  assign bubble   = |(therm & plus_one);
endmodule

// File: rtl/flash2_sequencer.sv
`timescale 1ns/1ps
module flash2_sequencer
  import flash2_pkg::*;
#(
  parameter int SETTLE = 1
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  output phase_t phase,
  output logic   take_est,
  output logic   take_crs,
  output logic   take_fin,
  output logic   take_latch
);
  localparam int CNT_W = (SETTLE > 0) ? $clog2(SETTLE + 1) : 1;

  logic [CNT_W-1:0] wait_q;
  logic             settled;

  assign settled = (wait_q == CNT_W'(SETTLE));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_IDLE;
      wait_q <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          wait_q <= '0;
          if (start) phase <= PH_EST;
        end
        PH_EST, PH_CRS, PH_FIN: begin
          if (settled) begin
            wait_q <= '0;
            phase  <= (phase == PH_EST) ? PH_CRS :
                      (phase == PH_CRS) ? PH_FIN : PH_LATCH;
          end else begin
            wait_q <= wait_q + CNT_W'(1);
          end
        end
        PH_LATCH: phase <= PH_IDLE;
        default:  phase <= PH_IDLE;
      endcase
    end
  end

  assign take_est   = (phase == PH_EST) && settled;
  assign take_crs   = (phase == PH_CRS) && settled;
  assign take_fin   = (phase == PH_FIN) && settled;
  assign take_latch = (phase == PH_LATCH);

  // R2: an idle start opens the estimate phase
  assert_start_opens_R2: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE && start) |=> (phase == PH_EST));
  // R2: leaving the fine phase always goes to latch
  assert_fine_to_latch_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(phase) == PH_FIN && phase != PH_FIN) |-> (phase == PH_LATCH));
  // R2: latch lasts a single cycle
  assert_latch_single_R2: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_LATCH) |=> (phase == PH_IDLE));
  // R8: a busy start never brings the sequence back to estimate early
  assert_busy_start_R8: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_CRS && start) |=> (phase != PH_EST));
endmodule

// File: rtl/flash2_combiner.sv
`timescale 1ns/1ps
// Window base, coarse code and final code, each limited to its range.
module flash2_combiner #(
  parameter int EST_OW   = 3,
  parameter int BANK_OW  = 5,
  parameter int CODE_W   = 6,
  parameter int FINE_W   = 4,
  parameter int WIN_STEP = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     take_est,
  input  logic                     take_crs,
  input  logic                     take_fin,
  input  logic                     take_latch,
  input  logic [EST_OW-1:0]        est_ones,
  input  logic                     est_bub,
  input  logic [BANK_OW-1:0]       bank_ones,
  input  logic                     bank_bub,
  output logic [CODE_W-1:0]        win_sel,
  output logic [CODE_W+FINE_W-1:0] result,
  output logic                     valid,
  output logic                     bubble
);
  localparam int          RES_W    = CODE_W + FINE_W;
  localparam logic [31:0] CODE_MAX = 32'((1 << CODE_W) - 1);
  localparam logic [31:0] RES_MAX  = 32'((1 << RES_W) - 1);

  logic [BANK_OW-1:0] fine_q;
  logic               bub_acc;
  logic [31:0]        base_full, crs_full, res_full;

  always_comb begin
    base_full = 32'(est_ones) * 32'(WIN_STEP);
    if (base_full > CODE_MAX) base_full = CODE_MAX;
    crs_full = 32'(win_sel) + 32'(bank_ones);
    if (crs_full > CODE_MAX) crs_full = CODE_MAX;
    res_full = (32'(win_sel) << FINE_W) + 32'(fine_q);
    if (res_full > RES_MAX) res_full = RES_MAX;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_sel <= '0;
      fine_q  <= '0;
      bub_acc <= 1'b0;
      result  <= '0;
      valid   <= 1'b0;
      bubble  <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (take_est) begin
        win_sel <= CODE_W'(base_full);
        bub_acc <= est_bub;
      end
      if (take_crs) begin
        win_sel <= CODE_W'(crs_full);
        bub_acc <= bub_acc | bank_bub;
      end
      if (take_fin) begin
        fine_q  <= bank_ones;
        bub_acc <= bub_acc | bank_bub;
      end
      if (take_latch) begin
        result <= RES_W'(res_full);
        bubble <= bub_acc;
        valid  <= 1'b1;
      end
    end
  end

  // R9: valid is a single-cycle pulse
  assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);
  // R9: result and flag only move together with valid
  assert_result_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !valid |-> ($stable(result) && $stable(bubble)));
endmodule

// File: rtl/flash2_decoder.sv
`timescale 1ns/1ps
module flash2_decoder
  import flash2_pkg::*;
#(
  parameter int EST_W    = 6,
  parameter int CODE_W   = 6,
  parameter int FINE_W   = 4,
  parameter int WIN_STEP = 8,
  parameter int SETTLE   = 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic [EST_W-1:0]           est_therm,
  input  logic [(1 << FINE_W)-1:0]   bank_therm,
  output logic [2:0]                 phase,
  output logic [CODE_W-1:0]          win_sel,
  output logic [CODE_W+FINE_W-1:0]   result,
  output logic                       valid,
  output logic                       bubble
);
  localparam int BANK_W  = 1 << FINE_W;
  localparam int EST_OW  = $clog2(EST_W + 1);
  localparam int BANK_OW = $clog2(BANK_W + 1);

  phase_t             phase_s;
  logic               take_est, take_crs, take_fin, take_latch;
  logic [EST_OW-1:0]  est_ones;
  logic [BANK_OW-1:0] bank_ones;
  logic               est_bub, bank_bub;

  flash2_sequencer #(.SETTLE(SETTLE)) u_seq (
    .clk(clk), .rst(rst), .start(start), .phase(phase_s),
    .take_est(take_est), .take_crs(take_crs),
    .take_fin(take_fin), .take_latch(take_latch)
  );

  flash2_therm_count #(.W(EST_W), .OW(EST_OW)) u_est_cnt (
    .therm(est_therm), .ones(est_ones), .bubble(est_bub)
  );

  flash2_therm_count #(.W(BANK_W), .OW(BANK_OW)) u_bank_cnt (
    .therm(bank_therm), .ones(bank_ones), .bubble(bank_bub)
  );

  flash2_combiner #(
    .EST_OW(EST_OW), .BANK_OW(BANK_OW), .CODE_W(CODE_W),
    .FINE_W(FINE_W), .WIN_STEP(WIN_STEP)
  ) u_comb (
    .clk(clk), .rst(rst),
    .take_est(take_est), .take_crs(take_crs),
    .take_fin(take_fin), .take_latch(take_latch),
    .est_ones(est_ones), .est_bub(est_bub),
    .bank_ones(bank_ones), .bank_bub(bank_bub),
    .win_sel(win_sel), .result(result), .valid(valid), .bubble(bubble)
  );

  assign phase = phase_s;

  // R10: the tap selection stays put for the whole of a phase
  assert_win_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (phase_s != PH_IDLE && phase_s == $past(phase_s)) |-> $stable(win_sel));
  // R4: the code's upper field is the coarse code, or one above it on fine overflow
  assert_fine_join_R4: assert property (@(posedge clk) disable iff (rst)
    valid |-> ((result[CODE_W+FINE_W-1:FINE_W] == win_sel) ||
               ({1'b0, result[CODE_W+FINE_W-1:FINE_W]} ==
                (CODE_W+1)'(win_sel) + (CODE_W+1)'(1))));
endmodule

// File: tb/tb_flash2_decoder.sv
`timescale 1ns/1ps
module tb_flash2_decoder;
  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [5:0]  est_therm;
  logic [15:0] bank_therm;
  logic [2:0]  phase;
  logic [5:0]  win_sel;
  logic [9:0]  result;
  logic        valid;
  logic        bubble;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // analog model controls
  int          vin     = 0;
  int          est_off = 0;
  bit          est_force_en = 0, crs_force_en = 0, fin_force_en = 0;
  logic [5:0]  est_force_v  = '0;
  logic [15:0] crs_force_v  = '0, fin_force_v = '0;
  bit          garbage_en   = 0;
  logic [2:0]  prev_phase;
  logic [5:0]  est_model;
  logic [15:0] bank_model;
  logic        in_settle;

  always #2 clk = ~clk;

  flash2_decoder dut (
    .clk(clk), .rst(rst), .start(start), .est_therm(est_therm),
    .bank_therm(bank_therm), .phase(phase), .win_sel(win_sel),
    .result(result), .valid(valid), .bubble(bubble)
  );

  always_ff @(posedge clk) prev_phase <= phase;

  // Behavioural comparators: estimator thresholds at (2k+3)*64 codes, coarse
  // taps every 16 codes from the window base, fine taps every code above
  // the subtracted coarse tap.
  always_comb begin
    for (int k = 0; k < 6; k++)
      est_model[k] = (vin >= (2 * k + 3) * 64 + est_off);
    for (int i = 0; i < 16; i++) begin
      if (phase == 3'd3)
        bank_model[i] = ((vin - int'(win_sel) * 16) >= i + 1);
      else
        bank_model[i] = (vin >= (int'(win_sel) + i + 1) * 16);
    end
    if (est_force_en) est_model = est_force_v;
    if (phase == 3'd2 && crs_force_en) bank_model = crs_force_v;
    if (phase == 3'd3 && fin_force_en) bank_model = fin_force_v;
    in_settle  = garbage_en && (phase != prev_phase);
    est_therm  = in_settle ? ~est_model  : est_model;
    bank_therm = in_settle ? ~bank_model : bank_model;
  end

  task automatic check(string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic clear_forces();
    est_force_en = 0; crs_force_en = 0; fin_force_en = 0;
    garbage_en = 0; est_off = 0;
  endtask

  // One conversion; exp_win_c is win_sel in coarse phase, exp_win_f in fine.
  task automatic run_conv(string tag, int v, int exp_win_c, int exp_win_f,
                          int exp_res, int exp_bub, bit poke);
    int cnt_ph[5];
    int first_valid = 0;
    int n_valid     = 0;
    int win_c       = -1;
    int win_f       = -1;
    int res_at_valid = 0;
    int res_later    = 0;
    int bub_later    = 0;
    for (int p = 0; p < 5; p++) cnt_ph[p] = 0;
    vin = v;
    @(negedge clk);
    start = 1'b1;
    for (int k = 1; k <= 14; k++) begin
      @(negedge clk);
      start = (poke && (k == 3 || k == 5)) ? 1'b1 : 1'b0;
      if (phase <= 3'd4) cnt_ph[phase] = cnt_ph[phase] + 1;
      if (phase == 3'd2 && win_c < 0) win_c = int'(win_sel);
      if (phase == 3'd3 && win_f < 0) win_f = int'(win_sel);
      if (valid) begin
        n_valid++;
        if (first_valid == 0) begin
          first_valid  = k;
          res_at_valid = int'(result);
        end
      end
      if (k == 13) begin
        res_later = int'(result);
        bub_later = int'(bubble);
      end
    end
    start = 1'b0;
    check({tag, " R2 latency"}, first_valid, 8);
    check({tag, " R2 estimate cycles"}, cnt_ph[1], 2);
    check({tag, " R2 coarse cycles"}, cnt_ph[2], 2);
    check({tag, " R2 fine cycles"}, cnt_ph[3], 2);
    check({tag, " R2 latch cycles"}, cnt_ph[4], 1);
    check({tag, " R8 R9 single valid"}, n_valid, 1);
    check({tag, " R3 coarse window"}, win_c, exp_win_c);
    check({tag, " R4 coarse code"}, win_f, exp_win_f);
    check({tag, " R5 result"}, res_at_valid, exp_res);
    check({tag, " R9 result held"}, res_later, exp_res);
    check({tag, " R7 bubble"}, bub_later, exp_bub);
    check({tag, " R4 win_sel held"}, int'(win_sel), exp_win_f);
  endtask

  task automatic t_reset();
    rst = 1'b1; start = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 phase in reset", int'(phase), 0);
    check("R1 valid in reset", int'(valid), 0);
    check("R1 result in reset", int'(result), 0);
    check("R1 win_sel in reset", int'(win_sel), 0);
    check("R1 bubble in reset", int'(bubble), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 phase after reset", int'(phase), 0);
    check("R1 valid after reset", int'(valid), 0);
  endtask

  task automatic t_basic();
    clear_forces();
    run_conv("R5 zero", 0, 0, 0, 0, 0, 0);
    run_conv("R5 full", 1023, 48, 63, 1023, 0, 0);
    run_conv("R3 mid", 500, 24, 31, 500, 0, 0);
  endtask

  task automatic t_correction();
    clear_forces();
    est_off = 60;
    run_conv("R6 estimate low", 710, 32, 44, 710, 0, 0);
    est_off = -60;
    run_conv("R6 estimate high", 570, 32, 35, 570, 0, 0);
    est_off = 0;
  endtask

  task automatic t_saturate();
    clear_forces();
    crs_force_en = 1; crs_force_v = 16'hFFFF;
    run_conv("R4 coarse limit", 1000, 48, 63, 1008, 0, 0);
    clear_forces();
    fin_force_en = 1; fin_force_v = 16'hFFFF;
    run_conv("R5 fine carry", 100, 0, 6, 112, 0, 0);
    run_conv("R5 code limit", 1023, 48, 63, 1023, 0, 0);
    clear_forces();
  endtask

  task automatic t_bubble();
    clear_forces();
    crs_force_en = 1; crs_force_v = 16'h000B;
    run_conv("R7 bank bubble", 500, 24, 27, 448, 1, 0);
    clear_forces();
    est_force_en = 1; est_force_v = 6'b000101;
    run_conv("R7 estimator bubble", 200, 16, 16, 256, 1, 0);
    clear_forces();
    run_conv("R7 flag clears", 321, 16, 20, 321, 0, 0);
  endtask

  task automatic t_busy();
    clear_forces();
    run_conv("R8 busy start", 321, 16, 20, 321, 0, 1);
  endtask

  task automatic t_settle();
    clear_forces();
    garbage_en = 1;
    run_conv("R10 settle ignored", 777, 40, 48, 777, 0, 0);
    garbage_en = 0;
  endtask

  initial begin
    t_reset();
    t_basic();
    t_correction();
    t_saturate();
    t_bubble();
    t_busy();
    t_settle();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule